// File: doc/BRIEF.md
# Random Word Generator with Seed-Fault Recovery

This block is a register-mapped source of random words for a processor bus. A 32-bit linear feedback shift register stands in for a real entropy source and produces a new word every few clock cycles while generation is switched on. Words collect in a small FIFO. Software polls a ready flag in the status register and pops words by reading the data register.

A test input, `seed_fault_i`, injects a seed fault. While generation is enabled and the fault is seen, the block stops producing words and raises two status bits: a live fault state bit and a sticky fault flag. Recovery is a fixed software sequence. Software writes 0 to the sticky flag. It then makes twelve discarding reads of the data register, with the fault input low. Only after that does the fault state bit drop and the FIFO start to refill. If the fault is still present, the flag is raised again and the count starts over.

An interrupt line combines the interrupt enable with the ready flag and the sticky error flags. A clock-error mask bit is stored, but there is no clock-error detection, so its status bits always read 0.

Top module: `randgen_periph`

## Requirements
- R1: The register map and bit layout are fixed. Control is at byte address 0x00, with run enable at bit 2, interrupt enable at bit 3 and the clock-check mask at bit 5. Status is at 0x04. Data is at 0x08. Control reads back only bits 2, 3 and 5, all other control bits read 0, and any unmapped address reads 0.
- R2: After reset, control reads 0, status reads 0 and `irq_o` is 0.
- R3: While run enable is 1 and no seed fault is active, a word is pushed every `STEP_CYCLES` cycles. Pushing stops while the FIFO holds 4 words. Word n is the generator state after n advances, starting from seed 0xACE12357. One advance is 32 shifts left, each shifting in the XOR of state bits 31, 21, 1 and 0 at bit 0.
- R4: Status bit 0 (ready) is 1 exactly while the FIFO holds at least one word. Each data read of a non-empty FIFO returns the oldest word and removes it.
- R5: A data read of an empty FIFO returns 0 and leaves status unchanged.
- R6: A seed fault seen while run enable is 1 sets status bit 2 (fault state) and status bit 6 (sticky fault flag). Words already in the FIFO stay readable.
- R7: Writing status with bit 6 = 0 clears the sticky fault flag. Writing it with bit 6 = 1 leaves the flag set.
- R8: After the flag is cleared and the fault input is low, the twelfth data read (empty reads count) makes status bit 2 drop, and generation resumes, continuing the word sequence. Until then the FIFO does not refill.
- R9: A fault input that stays high raises the sticky flag again right after software clears it, and the flush reads made while it is high do not end the fault state.
- R10: `irq_o` is 1 exactly when interrupt enable is 1 and either ready or the sticky fault flag is 1.
- R11: Writing 0 to control stops generation, and words already stored stay readable. Status bits 1 and 5 (clock-error state and flag) always read 0.
- R12: Writes to the data register are ignored, and the FIFO contents and word sequence are not altered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel_i | input | 1 | Register access in this cycle |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte address of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid in the cycle of the read |
| seed_fault_i | input | 1 | Test input that injects a seed fault |
| irq_o | output | 1 | Interrupt request |

## Verification
The checker checks on every cycle that the FIFO never passes its depth and that the sticky flag never stands without the fault state. It also checks that no word is added while a fault is active or generation is off, and that empty reads return 0. Further per-cycle checks cover the fault event setting both bits, a write of 1 keeping the flag, and the interrupt needing its enable. Only the bench's scenarios can show the properties that span many cycles: the exact word sequence across the disable, fault and recovery phases, and the twelve-read recovery count, including the case where the eleventh read is not enough. They also show re-arming under a fault that persists and the ignored data writes.

// File: rtl/randgen_pkg.sv
package randgen_pkg;
   // byte offsets decoded by software drivers
   localparam int unsigned OFS_CTRL = 32'h0;
   localparam int unsigned OFS_STAT = 32'h4;
   localparam int unsigned OFS_DATA = 32'h8;

   // control fields
   localparam int unsigned CB_RUN   = 2;
   localparam int unsigned CB_IRQEN = 3;
   localparam int unsigned CB_CKMSK = 5;

   // status fields
   localparam int unsigned SB_READY   = 0;
   localparam int unsigned SB_CKNOW   = 1;
   localparam int unsigned SB_SEEDNOW = 2;
   localparam int unsigned SB_CKFLG   = 5;
   localparam int unsigned SB_SEEDFLG = 6;

   localparam int unsigned BUS_W = 32;
endpackage

// File: rtl/randgen_lfsr.sv
module randgen_lfsr #(
   parameter int unsigned W     = 32,
   parameter logic [W-1:0] SEED = W'(32'hACE1_2357),
   parameter int unsigned STEPS = W
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         advance_i,
   output logic [W-1:0] word_o
);
   logic [W-1:0] taps;
   logic [W-1:0] state_q;
   logic [W-1:0] state_d;

   generate
      if (W == 32) begin : g_w32
         assign taps = W'(32'h8020_0003);
      end else if (W == 16) begin : g_w16
         assign taps = W'(16'hD008);
      end else begin : g_bad_w
         $error("randgen_lfsr: W must be 16 or 32");
         assign taps = '0;
      end
      if (SEED == '0) begin : g_bad_seed
         $error("randgen_lfsr: SEED must be nonzero");
      end
      if (STEPS < 1) begin : g_bad_steps
         $error("randgen_lfsr: STEPS must be at least 1");
      end
   endgenerate

   always_comb begin
      state_d = state_q;
      for (int unsigned i = 0; i < STEPS; i++) begin
         state_d = {state_d[W-2:0], ^(state_d & taps)};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SEED;
      end else if (advance_i) begin
         state_q <= state_d;
      end
   end

   assign word_o = state_d;
endmodule

// File: rtl/randgen_fifo.sv
module randgen_fifo #(
   parameter int unsigned W     = 32,
   parameter int unsigned DEPTH = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       push_i,
   input  logic [W-1:0]               data_i,
   input  logic                       pop_i,
   output logic [W-1:0]               data_o,
   output logic [$clog2(DEPTH+1)-1:0] fill_o,
   output logic                       full_o,
   output logic                       empty_o
);
   localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int unsigned CW = $clog2(DEPTH + 1);

   generate
      if (DEPTH < 1) begin : g_bad_depth
         $error("randgen_fifo: DEPTH must be at least 1");
      end
   endgenerate

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr, wr_inc, rd_inc;
   logic [CW-1:0] fill_q;
   logic          do_push, do_pop;

   assign full_o  = (fill_q == CW'(DEPTH));
   assign empty_o = (fill_q == '0);
   assign do_push = push_i && !full_o;
   assign do_pop  = pop_i && !empty_o;

   generate
      if ((1 << AW) == DEPTH) begin : g_pow2
         assign wr_inc = wr_ptr + AW'(1);
         assign rd_inc = rd_ptr + AW'(1);
      end else begin : g_wrap
         assign wr_inc = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + AW'(1);
         assign rd_inc = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + AW'(1);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (do_push) begin
         mem[wr_ptr] <= data_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         fill_q <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_inc;
         if (do_pop)  rd_ptr <= rd_inc;
         if (do_push && !do_pop) begin
            fill_q <= fill_q + CW'(1);
         end else if (do_pop && !do_push) begin
            fill_q <= fill_q - CW'(1);
         end
      end
   end

   assign data_o = mem[rd_ptr];
   assign fill_o = fill_q;
endmodule

// File: rtl/randgen_seed_mon.sv
module randgen_seed_mon #(
   parameter int unsigned FLUSH_READS = 12
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   input  logic fault_i,
   input  logic flag_wr_i,
   input  logic flag_wbit_i,
   input  logic data_rd_i,
   output logic seed_now_o,
   output logic seed_flag_o
);
   localparam int unsigned CW = $clog2(FLUSH_READS + 1);

   generate
      if (FLUSH_READS < 1) begin : g_bad_flush
         $error("randgen_seed_mon: FLUSH_READS must be at least 1");
      end
   endgenerate

   logic          now_q, flag_q;
   logic [CW-1:0] flush_q;
   logic          hit, flushing, flush_done;

   assign hit        = run_i && fault_i;
   assign flushing   = now_q && !flag_q;
   assign flush_done = flushing && (flush_q == CW'(FLUSH_READS)) && !fault_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         now_q   <= 1'b0;
         flag_q  <= 1'b0;
         flush_q <= '0;
      end else if (hit) begin
         now_q   <= 1'b1;
         flag_q  <= 1'b1;
         flush_q <= '0;
      end else begin
         if (flag_wr_i && !flag_wbit_i) begin
            flag_q <= 1'b0;
         end
         if (flush_done) begin
            now_q   <= 1'b0;
            flush_q <= '0;
         end else if (flushing && data_rd_i && flush_q != CW'(FLUSH_READS)) begin
            flush_q <= flush_q + CW'(1);
         end
      end
   end

   assign seed_now_o  = now_q;
   assign seed_flag_o = flag_q;
endmodule

// File: rtl/randgen_periph.sv
module randgen_periph
   import randgen_pkg::*;
#(
   parameter int unsigned ADDR_W      = 4,
   parameter int unsigned FIFO_WORDS  = 4,
   parameter int unsigned STEP_CYCLES = 4,
   parameter int unsigned FLUSH_READS = 12,
   parameter logic [31:0] LFSR_SEED   = 32'hACE1_2357
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel_i,
   input  logic              bus_wr_i,
   input  logic [ADDR_W-1:0] bus_addr_i,
   input  logic [31:0]       bus_wdata_i,
   output logic [31:0]       bus_rdata_o,
   input  logic              seed_fault_i,
   output logic              irq_o
);
   localparam int unsigned FILL_W = $clog2(FIFO_WORDS + 1);
   localparam int unsigned PACE_W = (STEP_CYCLES > 1) ? $clog2(STEP_CYCLES) : 1;

   generate
      if (ADDR_W < 4) begin : g_bad_addr
         $error("randgen_periph: ADDR_W must cover offset 0x08");
      end
      if (STEP_CYCLES < 1) begin : g_bad_step
         $error("randgen_periph: STEP_CYCLES must be at least 1");
      end
   endgenerate

   // address decode
   logic sel_ctrl, sel_stat, sel_data;
   logic wr_ctrl, wr_stat, rd_data;

   assign sel_ctrl = (bus_addr_i == ADDR_W'(OFS_CTRL));
   assign sel_stat = (bus_addr_i == ADDR_W'(OFS_STAT));
   assign sel_data = (bus_addr_i == ADDR_W'(OFS_DATA));
   assign wr_ctrl  = bus_sel_i && bus_wr_i && sel_ctrl;
   assign wr_stat  = bus_sel_i && bus_wr_i && sel_stat;
   assign rd_data  = bus_sel_i && !bus_wr_i && sel_data;

   // control register
   logic run_q, irqen_q, ckmsk_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q   <= 1'b0;
         irqen_q <= 1'b0;
         ckmsk_q <= 1'b0;
      end else if (wr_ctrl) begin
         run_q   <= bus_wdata_i[CB_RUN];
         irqen_q <= bus_wdata_i[CB_IRQEN];
         ckmsk_q <= bus_wdata_i[CB_CKMSK];
      end
   end

   // seed fault tracking
   logic seed_now, seed_flag;

   randgen_seed_mon #(
      .FLUSH_READS(FLUSH_READS)
   ) u_seed (
      .clk        (clk),
      .rst_n      (rst_n),
      .run_i      (run_q),
      .fault_i    (seed_fault_i),
      .flag_wr_i  (wr_stat),
      .flag_wbit_i(bus_wdata_i[SB_SEEDFLG]),
      .data_rd_i  (rd_data),
      .seed_now_o (seed_now),
      .seed_flag_o(seed_flag)
   );

   // word pacing
   logic fifo_full, fifo_empty, gen_ok, gen_tick;

   assign gen_ok = run_q && !seed_now && !fifo_full;

   generate
      if (STEP_CYCLES == 1) begin : g_every
         assign gen_tick = gen_ok;
      end else begin : g_paced
         logic [PACE_W-1:0] pace_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pace_q <= '0;
            end else if (gen_ok) begin
               pace_q <= (pace_q == PACE_W'(STEP_CYCLES - 1)) ? '0 : pace_q + PACE_W'(1);
            end
         end
         assign gen_tick = gen_ok && (pace_q == PACE_W'(STEP_CYCLES - 1));
      end
   endgenerate

   // noise stand-in and word store
   logic [31:0]       new_word, head_word;
   logic [FILL_W-1:0] fifo_fill;
   logic              pop;

   randgen_lfsr #(
      .W    (32),
      .SEED (LFSR_SEED),
      .STEPS(32)
   ) u_lfsr (
      .clk      (clk),
      .rst_n    (rst_n),
      .advance_i(gen_tick),
      .word_o   (new_word)
   );

   assign pop = rd_data && !fifo_empty;

   randgen_fifo #(
      .W    (32),
      .DEPTH(FIFO_WORDS)
   ) u_fifo (
      .clk    (clk),
      .rst_n  (rst_n),
      .push_i (gen_tick),
      .data_i (new_word),
      .pop_i  (pop),
      .data_o (head_word),
      .fill_o (fifo_fill),
      .full_o (fifo_full),
      .empty_o(fifo_empty)
   );

   // read mux
   logic [31:0] ctrl_view, stat_view;

   always_comb begin
      ctrl_view = '0;
      ctrl_view[CB_RUN]   = run_q;
      ctrl_view[CB_IRQEN] = irqen_q;
      ctrl_view[CB_CKMSK] = ckmsk_q;
      stat_view = '0;
      stat_view[SB_READY]   = !fifo_empty;
      stat_view[SB_CKNOW]   = 1'b0;
      stat_view[SB_SEEDNOW] = seed_now;
      stat_view[SB_CKFLG]   = 1'b0;
      stat_view[SB_SEEDFLG] = seed_flag;
   end

   always_comb begin
      bus_rdata_o = '0;
      if (bus_sel_i && !bus_wr_i) begin
         if (sel_ctrl) begin
            bus_rdata_o = ctrl_view;
         end else if (sel_stat) begin
            bus_rdata_o = stat_view;
         end else if (sel_data && !fifo_empty) begin
            bus_rdata_o = head_word;
         end
      end
   end

   assign irq_o = irqen_q && (!fifo_empty || seed_flag);

   logic unused_bits;
   assign unused_bits = ^{fifo_fill, bus_wdata_i};
endmodule

// File: rtl/randgen_checker.sv
module randgen_checker
   import randgen_pkg::*;
#(
   parameter int unsigned ADDR_W = 4,
   parameter int unsigned DEPTH  = 4,
   parameter int unsigned FILL_W = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sel,
   input logic              wr,
   input logic [ADDR_W-1:0] addr,
   input logic [31:0]       wdata,
   input logic [31:0]       rdata,
   input logic              fault,
   input logic              irq,
   input logic              run,
   input logic              irqen,
   input logic [FILL_W-1:0] fill,
   input logic              seed_now,
   input logic              seed_flag
);
   a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      fill <= FILL_W'(DEPTH));

   a_r6_flag_needs_state: assert property (@(posedge clk) disable iff (!rst_n)
      seed_flag |-> seed_now);

   a_r6_fault_sets_both: assert property (@(posedge clk) disable iff (!rst_n)
      (run && fault) |=> (seed_flag && seed_now));

   a_r8_no_refill_in_fault: assert property (@(posedge clk) disable iff (!rst_n)
      seed_now |=> fill <= $past(fill));

   a_r11_no_push_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> fill <= $past(fill));

   a_r5_empty_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && !wr && addr == ADDR_W'(OFS_DATA) && fill == '0) |-> rdata == '0);

   a_r7_one_keeps_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && wr && addr == ADDR_W'(OFS_STAT) && wdata[SB_SEEDFLG] && seed_flag) |=> seed_flag);

   a_r10_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> irqen);
endmodule

bind randgen_periph randgen_checker #(
   .ADDR_W(ADDR_W),
   .DEPTH (FIFO_WORDS),
   .FILL_W(FILL_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .sel      (bus_sel_i),
   .wr       (bus_wr_i),
   .addr     (bus_addr_i),
   .wdata    (bus_wdata_i),
   .rdata    (bus_rdata_o),
   .fault    (seed_fault_i),
   .irq      (irq_o),
   .run      (run_q),
   .irqen    (irqen_q),
   .fill     (fifo_fill),
   .seed_now (seed_now),
   .seed_flag(seed_flag)
);

// File: tb/randgen_periph_tb.sv
module randgen_periph_tb;
   localparam int CLK_PERIOD = 10;
   localparam logic [3:0] A_CTRL = 4'h0, A_STAT = 4'h4, A_DATA = 4'h8, A_NONE = 4'hC;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sel = 1'b0, wr = 1'b0, fault = 1'b0;
   logic [3:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        irq;
   int          n_cmp = 0, n_bad = 0;
   bit          done = 1'b0;
   logic [31:0] model_st = 32'hACE1_2357;

   always #(CLK_PERIOD / 2) clk = ~clk;

   randgen_periph u_dut (
      .clk(clk), .rst_n(rst_n), .bus_sel_i(sel), .bus_wr_i(wr), .bus_addr_i(addr),
      .bus_wdata_i(wdata), .bus_rdata_o(rdata), .seed_fault_i(fault), .irq_o(irq)
   );

   function automatic logic [31:0] adv(logic [31:0] s);
      for (int i = 0; i < 32; i++) s = {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
      return s;
   endfunction

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic bus_wr(logic [3:0] a, logic [31:0] d);
      @(negedge clk);
      sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      sel = 1'b0; wr = 1'b0;
   endtask

   task automatic bus_rd(logic [3:0] a, output logic [31:0] d);
      @(negedge clk);
      sel = 1'b1; wr = 1'b0; addr = a;
      #1 d = rdata;
      @(negedge clk);
      sel = 1'b0;
   endtask

   task automatic expect_reg(string tag, logic [3:0] a, logic [31:0] exp);
      logic [31:0] v;
      bus_rd(a, v);
      check(tag, v, exp);
   endtask

   task automatic pop_word(string tag);
      logic [31:0] v;
      bus_rd(A_DATA, v);
      model_st = adv(model_st);
      check(tag, v, model_st);
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic t_reset;
      logic [31:0] v;
      expect_reg("R2 ctrl after reset", A_CTRL, 32'h0);
      expect_reg("R2 status after reset", A_STAT, 32'h0);
      check("R2 irq after reset", {31'b0, irq}, 32'h0);
      bus_rd(A_DATA, v);
      check("R5 empty data read", v, 32'h0);
      expect_reg("R1 unmapped read", A_NONE, 32'h0);
   endtask

   task automatic t_ctrl_and_fill;
      bus_wr(A_CTRL, 32'hFFFF_FFFF);
      expect_reg("R1 ctrl readback mask", A_CTRL, 32'h0000_002C);
      bus_wr(A_CTRL, 32'h0000_0024);
      idle(40);
      expect_reg("R3 ready after run, R11 clock bits 0", A_STAT, 32'h1);
      bus_wr(A_CTRL, 32'h0);
      expect_reg("R11 ctrl cleared", A_CTRL, 32'h0);
      idle(30);
      for (int i = 0; i < 4; i++) pop_word("R3/R4 word order");
      expect_reg("R4 ready drops when empty", A_STAT, 32'h0);
      expect_reg("R5 empty read returns 0", A_DATA, 32'h0);
      expect_reg("R5 status unchanged after empty read", A_STAT, 32'h0);
      idle(30);
      expect_reg("R11 no generation while off", A_STAT, 32'h0);
   endtask

   task automatic t_data_write;
      bus_wr(A_CTRL, 32'h24);
      idle(40);
      bus_wr(A_DATA, 32'hDEAD_BEEF);
      bus_wr(A_CTRL, 32'h0);
      for (int i = 0; i < 4; i++) pop_word("R12 data write ignored");
      expect_reg("R12 no extra word stored", A_DATA, 32'h0);
   endtask

   task automatic t_irq;
      bus_wr(A_CTRL, 32'h2C);
      idle(40);
      #1 check("R10 irq with enable and data", {31'b0, irq}, 32'h1);
      bus_wr(A_CTRL, 32'h20);
      #1 check("R10 irq off without enable", {31'b0, irq}, 32'h0);
      bus_wr(A_CTRL, 32'h08);
      #1 check("R10 irq back on with data held", {31'b0, irq}, 32'h1);
      for (int i = 0; i < 4; i++) pop_word("R10 drain");
      #1 check("R10 irq off once empty", {31'b0, irq}, 32'h0);
   endtask

   task automatic t_seed_recover;
      logic [31:0] v;
      bus_wr(A_CTRL, 32'h2C);
      idle(40);
      @(negedge clk); fault = 1'b1;
      idle(2); fault = 1'b0;
      expect_reg("R6 fault sets bits 2 and 6", A_STAT, 32'h45);
      for (int i = 0; i < 4; i++) pop_word("R6 stored words survive");
      expect_reg("R6 fault bits after drain", A_STAT, 32'h44);
      #1 check("R10 irq from sticky flag", {31'b0, irq}, 32'h1);
      idle(30);
      expect_reg("R8 no refill during fault", A_STAT, 32'h44);
      bus_wr(A_STAT, 32'h40);
      expect_reg("R7 write 1 keeps flag", A_STAT, 32'h44);
      bus_wr(A_STAT, 32'h0);
      expect_reg("R7 write 0 clears flag", A_STAT, 32'h04);
      #1 check("R10 irq off after clear", {31'b0, irq}, 32'h0);
      for (int i = 0; i < 11; i++) begin
         bus_rd(A_DATA, v);
         check("R8 flush read is zero", v, 32'h0);
      end
      expect_reg("R8 fault state held after 11 reads", A_STAT, 32'h04);
      bus_rd(A_DATA, v);
      idle(2);
      bus_rd(A_STAT, v);
      check("R8 fault state ends after 12 reads", v & 32'h44, 32'h0);
      idle(40);
      expect_reg("R8 refill after recovery", A_STAT, 32'h1);
      for (int i = 0; i < 4; i++) pop_word("R8 sequence continues");
   endtask

   task automatic t_persist;
      logic [31:0] v;
      bus_wr(A_CTRL, 32'h24);
      idle(40);
      @(negedge clk); fault = 1'b1;
      idle(2);
      for (int i = 0; i < 4; i++) pop_word("R9 stored words");
      bus_wr(A_STAT, 32'h0);
      expect_reg("R9 flag re-raised under fault", A_STAT, 32'h44);
      for (int i = 0; i < 12; i++) bus_rd(A_DATA, v);
      fault = 1'b0;
      idle(3);
      expect_reg("R9 reads under fault do not recover", A_STAT, 32'h44);
      bus_wr(A_STAT, 32'h0);
      for (int i = 0; i < 12; i++) bus_rd(A_DATA, v);
      idle(2);
      bus_rd(A_STAT, v);
      check("R9 recovery once fault gone", v & 32'h44, 32'h0);
      idle(40);
      for (int i = 0; i < 4; i++) pop_word("R9 sequence after recovery");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_ctrl_and_fill();
      t_data_write();
      t_irq();
      t_seed_recover();
      t_persist();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule